// File: doc/BRIEF.md
# Global Error Status Register Block

This block collects error events for a device management function and exposes them through 64-bit registers on a simple read/write port. Five error groups are kept: device-internal, PCIe link 0, PCIe link 1, non-fatal and catastrophic/fatal. Each group has a mask register and a sticky status register. An error input that is asserted while its mask bit is clear sets its status bit on the next clock edge. The bit then stays set until software clears it or, for the two severity groups, until reset.

Software clears the device-internal and link groups by writing ones to the status bits it wants to drop. The block also records the first logging event and the one that follows it. Once every status register is empty again, both records are rearmed. A small injection register feeds test errors into the severity groups through the same logging path that real errors use.

Error vectors are `ERR_W` bits wide, zero-extended to 64 bits on reads. A read request returns its data on `reg_rdata` one clock after it is issued.

Top module: `glb_err_regs`

## Requirements
- R1: After reset, every register reads zero, except bit 6 of the device-internal mask. That bit reads 1 when parameter `REVISION` is 0 and 0 otherwise, so that source starts masked.
- R2: Register offsets (byte address) are as follows. Device mask is 0x08 and status is 0x10. Link 0 mask is 0x18 and status is 0x20. Link 1 mask is 0x28 and status is 0x30. First record is 0x38 and next record is 0x40. Non-fatal mask is 0x48 and status is 0x50. Catastrophic/fatal mask is 0x58 and status is 0x60. Injection is 0x68. Mask and status registers read back their `ERR_W` bits zero-extended. A read issued with `reg_rd` in one cycle presents its data on `reg_rdata` after the next rising edge, and `reg_rdata` holds that value until the next read.
- R3: An error input bit that is high during a clock edge while its mask bit is 0 sets the matching status bit at that edge. The bit stays set after the input falls.
- R4: A status bit whose mask bit is 1 is not set by its input.
- R5: Writing a pattern to the device, link 0 or link 1 status register clears each status bit where the pattern holds a 1, and leaves the other bits unchanged. If an error arrives for a bit in the same cycle that the bit is cleared, the error wins and the bit stays set.
- R6: Writes to the non-fatal and catastrophic/fatal status registers have no effect. Their bits stay set until reset.
- R7: The injection register stores and reads back all 64 bits written to it. Bit 0 drives catastrophic/fatal bit 0, bit 1 drives catastrophic/fatal bit 1, and bit 2 drives non-fatal bit 0. Each of these is ORed into the raw input for as long as it is set. Bits above 2 inject nothing.
- R8: The first-error record has the following format: bit 63 is valid, bits [62:60] are the group code (device 0, link 0 = 1, link 1 = 2, non-fatal 3, catastrophic/fatal 4), and bits [ERR_W-1:0] are the newly set status bits of that group. It captures the first edge at which any status bit newly sets. When several groups set at once, the lowest group code is recorded.
- R9: The next-error record uses the same format. It captures the first newly-setting edge strictly after the first record became valid.
- R10: Once valid, the two records do not change while any status bit is set. When all five status registers become zero, both records return to zero and are armed again.
- R11: Reads of any other offset return zero. Writes to unmapped offsets and to the two records have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| err_dev_i | input | ERR_W | Device-internal error inputs |
| err_pcie0_i | input | ERR_W | PCIe link 0 error inputs |
| err_pcie1_i | input | ERR_W | PCIe link 1 error inputs |
| err_nonfatal_i | input | ERR_W | Non-fatal error inputs |
| err_catfatal_i | input | ERR_W | Catastrophic/fatal error inputs |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write-one-to-clear on a status register and a fresh error on the same bit: the bench drives the clear and the error in one cycle, and expects the bit to read back still set. The second pair is simultaneous errors in two groups: the bench raises a device and a link 1 error at the same edge, and expects the first record to name the device group, with the next record filled only by a later event. A sweep over every bit of every clearable group checks that each bit sets and clears, with expected words computed as single shifted ones.

// File: rtl/glb_err_pkg.sv
package glb_err_pkg;
  localparam int DW      = 64;
  localparam int NUM_GRP = 5;

  // group codes, also the capture priority (lower wins)
  localparam int G_DEV = 0;
  localparam int G_LK0 = 1;
  localparam int G_LK1 = 2;
  localparam int G_NF  = 3;
  localparam int G_CF  = 4;

  localparam logic [7:0] OFF_FIRST  = 8'h38;
  localparam logic [7:0] OFF_NEXT   = 8'h40;
  localparam logic [7:0] OFF_INJECT = 8'h68;

  function automatic logic [7:0] mask_off(input int g);
    case (g)
      G_DEV:   mask_off = 8'h08;
      G_LK0:   mask_off = 8'h18;
      G_LK1:   mask_off = 8'h28;
      G_NF:    mask_off = 8'h48;
      default: mask_off = 8'h58;
    endcase
  endfunction

  function automatic logic [7:0] stat_off(input int g);
    stat_off = mask_off(g) + 8'h08;
  endfunction
endpackage

// File: rtl/err_group.sv
module err_group #(
  parameter int ERR_W = 16,
  parameter bit CLEARABLE = 1'b1,
  parameter logic [ERR_W-1:0] RST_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] raw,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic [ERR_W-1:0] wdata,
  output logic [ERR_W-1:0] mask_q,
  output logic [ERR_W-1:0] stat_q,
  output logic [ERR_W-1:0] new_bits,
  output logic [ERR_W-1:0] stat_nxt
);
  logic [ERR_W-1:0] set_v;
  logic [ERR_W-1:0] clr_v;

  always_comb begin
    set_v    = raw & ~mask_q;
    clr_v    = (CLEARABLE && stat_we) ? wdata : '0;
    new_bits = set_v & ~stat_q;
    stat_nxt = (stat_q & ~clr_v) | set_v;   // set wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= RST_MASK;
      stat_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      stat_q <= stat_nxt;
    end
  end

  // R4: a masked bit never rises
  a_r4_masked_no_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  // R3/R6: without a clear write, no status bit falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (!stat_we || !CLEARABLE) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R5: a bit hit by a raw error is set on the next edge even when cleared
  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(raw & ~mask_q)) == $past(raw & ~mask_q)));
endmodule

// File: rtl/err_order_log.sv
module err_order_log
  import glb_err_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_GRP*ERR_W-1:0] new_flat,
  input  logic                     any_nxt,
  output logic [DW-1:0]            first_q,
  output logic [DW-1:0]            next_q
);
  logic          hit;
  logic [DW-1:0] rec;

  // lowest group code with newly-set bits wins
  always_comb begin
    hit = 1'b0;
    rec = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (|new_flat[g*ERR_W +: ERR_W]) begin
        hit = 1'b1;
        rec = '0;
        rec[DW-1] = 1'b1;
        rec[DW-2 -: 3] = 3'(g);
        rec[ERR_W-1:0] = new_flat[g*ERR_W +: ERR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (first_q[DW-1] && !any_nxt) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (hit) begin
      if (!first_q[DW-1])     first_q <= rec;
      else if (!next_q[DW-1]) next_q  <= rec;
    end
  end

  // R10: a valid first record holds while errors remain
  a_r10_first_hold: assert property (@(posedge clk) disable iff (rst)
    (first_q[DW-1] && any_nxt) |=> $stable(first_q));

  // R9: the next record is never valid without a first record
  a_r9_next_after_first: assert property (@(posedge clk) disable iff (rst)
    next_q[DW-1] |-> first_q[DW-1]);
endmodule

// File: rtl/glb_err_regs.sv
module glb_err_regs
  import glb_err_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int REVISION = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [ERR_W-1:0]  err_dev_i,
  input  logic [ERR_W-1:0]  err_pcie0_i,
  input  logic [ERR_W-1:0]  err_pcie1_i,
  input  logic [ERR_W-1:0]  err_nonfatal_i,
  input  logic [ERR_W-1:0]  err_catfatal_i
);
  localparam int HOLD_BIT = 6;
  localparam logic [ERR_W-1:0] DEV_RST_MASK =
    (REVISION == 0) ? ERR_W'(1) << HOLD_BIT : '0;

  logic [DW-1:0]            inj_q;
  logic [ERR_W-1:0]         raw      [NUM_GRP];
  logic [ERR_W-1:0]         mask_v   [NUM_GRP];
  logic [ERR_W-1:0]         stat_v   [NUM_GRP];
  logic [ERR_W-1:0]         nxt_v    [NUM_GRP];
  logic [NUM_GRP*ERR_W-1:0] new_flat;
  logic [NUM_GRP-1:0]       grp_nz;
  logic [DW-1:0]            first_q, next_q;
  logic [7:0]               a8;
  logic [DW-1:0]            rd_mux;

  assign a8 = 8'(reg_addr);

  always_comb begin
    raw[G_DEV] = err_dev_i;
    raw[G_LK0] = err_pcie0_i;
    raw[G_LK1] = err_pcie1_i;
    raw[G_NF]  = err_nonfatal_i;
    raw[G_CF]  = err_catfatal_i;
    raw[G_CF][0] = err_catfatal_i[0] | inj_q[0];
    raw[G_CF][1] = err_catfatal_i[1] | inj_q[1];
    raw[G_NF][0] = err_nonfatal_i[0] | inj_q[2];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    err_group #(
      .ERR_W    (ERR_W),
      .CLEARABLE(g < G_NF),
      .RST_MASK ((g == G_DEV) ? DEV_RST_MASK : '0)
    ) grp_i (
      .clk     (clk),
      .rst     (rst),
      .raw     (raw[g]),
      .mask_we (reg_wr && a8 == mask_off(g)),
      .stat_we (reg_wr && a8 == stat_off(g)),
      .wdata   (reg_wdata[ERR_W-1:0]),
      .mask_q  (mask_v[g]),
      .stat_q  (stat_v[g]),
      .new_bits(new_flat[g*ERR_W +: ERR_W]),
      .stat_nxt(nxt_v[g])
    );
    assign grp_nz[g] = |nxt_v[g];
  end

  err_order_log #(.ERR_W(ERR_W)) log_i (
    .clk     (clk),
    .rst     (rst),
    .new_flat(new_flat),
    .any_nxt (|grp_nz),
    .first_q (first_q),
    .next_q  (next_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                               inj_q <= '0;
    else if (reg_wr && a8 == OFF_INJECT)   inj_q <= reg_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (a8 == OFF_FIRST)  rd_mux = first_q;
    if (a8 == OFF_NEXT)   rd_mux = next_q;
    if (a8 == OFF_INJECT) rd_mux = inj_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (a8 == mask_off(g)) rd_mux = DW'(mask_v[g]);
      if (a8 == stat_off(g)) rd_mux = DW'(stat_v[g]);
    end
    if (reg_addr != ADDR_W'(a8)) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R11: a read of an unmapped offset returns zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (a8[2:0] != 3'b000 || a8 < 8'h08 || a8 > 8'h68)) |=> (reg_rdata == '0));

  // R7: an injection bit held for a cycle leaves its catastrophic bit set
  a_r7_inject_logs: assert property (@(posedge clk) disable iff (rst)
    (inj_q[0] && mask_v[G_CF][0] == 1'b0) |=> stat_v[G_CF][0]);
endmodule

// File: tb/glb_err_regs_tb.sv
module glb_err_regs_tb_top;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic [EW-1:0] e_dev = '0, e_l0 = '0, e_l1 = '0, e_nf = '0, e_cf = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  glb_err_regs #(.ERR_W(EW), .ADDR_W(8), .REVISION(0)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_dev_i(e_dev), .err_pcie0_i(e_l0), .err_pcie1_i(e_l1),
    .err_nonfatal_i(e_nf), .err_catfatal_i(e_cf));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input int g, input logic [EW-1:0] v);
    @(negedge clk);
    case (g) 0: e_dev = v; 1: e_l0 = v; 2: e_l1 = v; 3: e_nf = v; default: e_cf = v; endcase
    @(negedge clk);
    e_dev = '0; e_l0 = '0; e_l1 = '0; e_nf = '0; e_cf = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] moff(input int g);
    logic [7:0] t [5] = '{8'h08, 8'h18, 8'h28, 8'h48, 8'h58};
    return t[g];
  endfunction

  initial begin
    logic [63:0] d;
    do_reset();
    // R1 reset values
    for (int g = 0; g < 5; g++) begin
      rd(moff(g), d);
      check("R1 mask reset", d, (g == 0) ? 64'h40 : 64'h0);
      rd(moff(g) + 8'h08, d);
      check("R1 status reset", d, 64'h0);
    end
    rd(8'h38, d); check("R1 first reset", d, 0);
    rd(8'h40, d); check("R1 next reset", d, 0);
    rd(8'h68, d); check("R1 inject reset", d, 0);

    // R4: reset-masked bit 6 of device group
    pulse(0, 16'h0040);
    rd(8'h10, d); check("R4 held bit masked", d, 0);
    wr(8'h08, 64'h0);
    pulse(0, 16'h0040);
    rd(8'h10, d); check("R3 unmasked bit 6 logs", d, 64'h40);
    wr(8'h10, 64'h40);
    rd(8'h10, d); check("R5 clear bit 6", d, 0);

    // R3/R5 sweep of clearable groups
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < EW; b++) begin
        pulse(g, EW'(1) << b);
        rd(moff(g) + 8'h08, d);
        check("R3 bit sets and sticks", d, 64'h1 << b);
        wr(moff(g) + 8'h08, 64'h1 << b);
        rd(moff(g) + 8'h08, d);
        check("R5 w1c clears", d, 0);
      end
    end

    // R5 partial clear
    pulse(1, 16'hA5A5);
    wr(8'h20, 64'h0F0F);
    rd(8'h20, d); check("R5 partial clear", d, 64'hA0A0);
    wr(8'h20, 64'hFFFF);

    // R5 set beats clear in the same cycle
    pulse(0, 16'h0004);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 64'h4; e_dev = 16'h0004;
    @(negedge clk); reg_wr = 1'b0; e_dev = '0;
    rd(8'h10, d); check("R5 error wins over clear", d, 64'h4);
    wr(8'h10, 64'h4);

    // R2/R4 mask all ones
    wr(8'h28, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h28, d); check("R2 mask readback width", d, 64'hFFFF);
    pulse(2, 16'hFFFF);
    rd(8'h30, d); check("R4 fully masked group", d, 0);
    wr(8'h28, 64'h0);

    // R8/R9/R10 ordering
    do_reset();
    @(negedge clk); e_dev = 16'h0008; e_l1 = 16'h0020;
    @(negedge clk); e_dev = '0; e_l1 = '0;
    pulse(1, 16'h0002);
    pulse(2, 16'h0001);
    rd(8'h38, d); check("R8 first record priority", d, 64'h8000_0000_0000_0008);
    rd(8'h40, d); check("R9 next record", d, 64'h9000_0000_0000_0002);
    wr(8'h38, 64'h0); wr(8'h40, 64'h0);
    rd(8'h38, d); check("R11 first not writable", d, 64'h8000_0000_0000_0008);
    wr(8'h10, 64'hFFFF);
    rd(8'h38, d); check("R10 first held", d, 64'h8000_0000_0000_0008);
    wr(8'h20, 64'hFFFF);
    wr(8'h30, 64'hFFFF);
    rd(8'h38, d); check("R10 first rearmed", d, 0);
    rd(8'h40, d); check("R10 next rearmed", d, 0);
    pulse(2, 16'h0010);
    rd(8'h38, d); check("R8 recapture after rearm", d, 64'hA000_0000_0000_0010);
    wr(8'h30, 64'hFFFF);

    // R11 unmapped
    wr(8'h00, 64'hDEAD); wr(8'h70, 64'hBEEF);
    rd(8'h00, d); check("R11 unmapped 0x00", d, 0);
    rd(8'h70, d); check("R11 unmapped 0x70", d, 0);
    rd(8'h14, d); check("R11 unaligned", d, 0);

    // R6 read-only severity status
    pulse(3, 16'h0100);
    pulse(4, 16'h0080);
    wr(8'h50, 64'hFFFF); wr(8'h60, 64'hFFFF);
    rd(8'h50, d); check("R6 nonfatal not cleared", d, 64'h100);
    rd(8'h60, d); check("R6 catfatal not cleared", d, 64'h80);
    wr(8'h48, 64'h0200);
    pulse(3, 16'h0200);
    rd(8'h50, d); check("R4 nonfatal masked", d, 64'h100);

    // R7 injection
    wr(8'h68, 64'hF000_0000_0000_00F5);
    rd(8'h68, d); check("R7 inject readback", d, 64'hF000_0000_0000_00F5);
    rd(8'h60, d); check("R7 inject catastrophic", d, 64'h81);
    rd(8'h50, d); check("R7 inject nonfatal", d, 64'h101);
    wr(8'h68, 64'h2);
    rd(8'h60, d); check("R7 inject fatal", d, 64'h83);
    wr(8'h68, 64'hFFF8);
    rd(8'h60, d); check("R7 upper bits inject nothing", d, 64'h83);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule